// File: doc/BRIEF.md
# Padded Long Move Engine

This block carries out a long memory-to-memory byte move described by four 32-bit register values. The destination address and length arrive from one register pair. The source address, the source length and a pad byte arrive from the other pair. The two register numbers are also supplied, so the engine can refuse a pair that does not start on an even register. Source bytes are copied into the destination one at a time, in ascending address order. When the source is exhausted, the rest of the destination is filled with the pad byte.

Memory is a single byte-wide port with a request/acknowledge handshake. When the move ends, the engine returns the four updated register values and a 2-bit status. A move is refused outright when the destination start falls inside the part of the source that is still to be copied, because copying forward would then overwrite source bytes before they are read.

Top module: `pad_move_engine`

## Requirements
- R1: If bit 0 of either register number is 1, the engine makes no memory request, raises `specErr` with `done`, and returns the four inputs with bits 31:24 cleared.
- R2: Bits 23:0 of each address word and length word are used. Bits 31:24 of the two address words and of the destination length word have no effect.
- R3: The engine copies min(destination length, source length) bytes. For each byte it reads the source address and then writes that byte to the destination address.
- R4: The pad byte is bits 31:24 of the source length word. It is written to every destination position after the copied bytes, and never before the copy count is used up.
- R5: Let offset = (destination − source) mod 2^24. If offset is nonzero and below the copy count, no memory access is made and status is 3. An offset of zero, or one at or above the copy count, lets the move proceed.
- R6: Both addresses step by one after each byte and wrap from 0xFFFFFF to 0x000000.
- R7: On normal completion, the destination address has advanced by the destination length, the destination length is 0, the source address has advanced by the copy count, and the source length has dropped by the copy count. Bits 31:24 of all four results are 0.
- R8: When not refused, status is 0 if the two lengths are equal, 1 if the destination is shorter, and 2 if the destination is longer.
- R9: For a zero destination length, a refusal or an odd register number, `done` is high in the second cycle after the cycle in which `start` is sampled, with no memory cycles.
- R10: A request is held with stable address, direction and write data until it is acknowledged. No request is made while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a move; taken only while idle |
| dstRegNum | input | 4 | Number of the destination register pair |
| srcRegNum | input | 4 | Number of the source register pair |
| dstAddrIn | input | 32 | Destination address word |
| dstLenIn | input | 32 | Destination length word |
| srcAddrIn | input | 32 | Source address word |
| srcLenIn | input | 32 | Pad byte (31:24) and source length (23:0) |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| specErr | output | 1 | Odd register number seen; held until next start |
| status | output | 2 | Completion code, held until next start |
| dstAddrOut | output | 32 | Updated destination address |
| dstLenOut | output | 32 | Updated destination length |
| srcAddrOut | output | 32 | Updated source address |
| srcLenOut | output | 32 | Updated source length |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | 24 | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with acknowledge |
| memAck | input | 1 | Completes the current request at the clock edge |

## Verification
A request issued by the engine appears on the bus in the cycle after the edge that ends the previous transfer. The bench raises the acknowledge at a falling edge and, in that same half cycle, compares the transfer against a queue of expected reads and writes computed from the two lengths and a shadow copy of memory. When a move finishes without memory traffic, `done` is due exactly two cycles after `start` is sampled, and the bench counts falling edges to check that. For every other move, the results and status are compared at the falling edge where `done` is high, which is one cycle after the last acknowledge.

// File: rtl/lme_pkg.sv
package lme_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_READ,
    S_WRITE,
    S_PAD,
    S_FINISH
  } moveState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic latchData;
    logic stepCopy;
    logic stepPad;
    logic useSrc;
    logic usePad;
    logic setStatus;
    logic setSpec;
  } dpCtrl_t;

endpackage

// File: rtl/lme_datapath.sv
module lme_datapath
  import lme_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int REGN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [REGN_W-1:0] dstRegNum,
  input  logic [REGN_W-1:0] srcRegNum,
  input  logic [WORD_W-1:0] dstAddrIn,
  input  logic [WORD_W-1:0] dstLenIn,
  input  logic [WORD_W-1:0] srcAddrIn,
  input  logic [WORD_W-1:0] srcLenIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic              specBad,
  output logic              overlapBad,
  output logic              dstZero,
  output logic              dstLast,
  output logic              copyZero,
  output logic              copyLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              specErr,
  output logic [1:0]        status,
  output logic [WORD_W-1:0] dstAddrOut,
  output logic [WORD_W-1:0] dstLenOut,
  output logic [WORD_W-1:0] srcAddrOut,
  output logic [WORD_W-1:0] srcLenOut
);

  localparam int HI_W = WORD_W - ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] dstAddr, dstLen, srcAddr, srcLen, copyLeft;
  logic [DATA_W-1:0] padByte, dataByte;
  logic              regOdd;
  logic [1:0]        statusR, lenStatus;
  logic              specErrR;
  logic [ADDR_W-1:0] inDstLen, inSrcLen, offset;

  // bits that carry no meaning for the move
  logic unusedBits;
  assign unusedBits = ^{dstAddrIn[WORD_W-1:ADDR_W], dstLenIn[WORD_W-1:ADDR_W],
                        srcAddrIn[WORD_W-1:ADDR_W], dstRegNum[REGN_W-1:1],
                        srcRegNum[REGN_W-1:1]};

  assign inDstLen = dstLenIn[ADDR_W-1:0];
  assign inSrcLen = srcLenIn[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstAddr  <= '0;
      dstLen   <= '0;
      srcAddr  <= '0;
      srcLen   <= '0;
      copyLeft <= '0;
      padByte  <= '0;
      dataByte <= '0;
      regOdd   <= 1'b0;
      statusR  <= 2'd0;
      specErrR <= 1'b0;
    end else begin
      if (ctrl.load) begin
        dstAddr  <= dstAddrIn[ADDR_W-1:0];
        dstLen   <= inDstLen;
        srcAddr  <= srcAddrIn[ADDR_W-1:0];
        srcLen   <= inSrcLen;
        copyLeft <= (inDstLen < inSrcLen) ? inDstLen : inSrcLen;
        padByte  <= srcLenIn[WORD_W-1 -: DATA_W];
        regOdd   <= dstRegNum[0] | srcRegNum[0];
        statusR  <= 2'd0;
        specErrR <= 1'b0;
      end
      if (ctrl.latchData) dataByte <= memRdata;
      if (ctrl.stepCopy) begin
        dstAddr  <= dstAddr + ONE;
        dstLen   <= dstLen - ONE;
        srcAddr  <= srcAddr + ONE;
        srcLen   <= srcLen - ONE;
        copyLeft <= copyLeft - ONE;
      end
      if (ctrl.stepPad) begin
        dstAddr <= dstAddr + ONE;
        dstLen  <= dstLen - ONE;
      end
      if (ctrl.setStatus) statusR <= overlapBad ? 2'd3 : lenStatus;
      if (ctrl.setSpec) specErrR <= 1'b1;
    end
  end

  // forward copy is harmful only when the destination starts inside the unread source
  assign offset     = dstAddr - srcAddr;
  assign overlapBad = (offset != '0) && (offset < copyLeft);

  always_comb begin
    if (dstLen == srcLen)     lenStatus = 2'd0;
    else if (dstLen < srcLen) lenStatus = 2'd1;
    else                      lenStatus = 2'd2;
  end

  assign specBad  = regOdd;
  assign dstZero  = (dstLen == '0);
  assign dstLast  = (dstLen == ONE);
  assign copyZero = (copyLeft == '0);
  assign copyLast = (copyLeft == ONE);

  assign memAddr  = ctrl.useSrc ? srcAddr : dstAddr;
  assign memWdata = ctrl.usePad ? padByte : dataByte;

  assign specErr    = specErrR;
  assign status     = statusR;
  assign dstAddrOut = {{HI_W{1'b0}}, dstAddr};
  assign dstLenOut  = {{HI_W{1'b0}}, dstLen};
  assign srcAddrOut = {{HI_W{1'b0}}, srcAddr};
  assign srcLenOut  = {{HI_W{1'b0}}, srcLen};

  // R4
  pad_after_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepPad |-> copyLeft == '0);

endmodule

// File: rtl/lme_control.sv
module lme_control
  import lme_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memAck,
  input  logic    specBad,
  input  logic    overlapBad,
  input  logic    dstZero,
  input  logic    dstLast,
  input  logic    copyZero,
  input  logic    copyLast,
  output dpCtrl_t ctrl,
  output logic    memReq,
  output logic    memWe,
  output logic    busy,
  output logic    done
);

  moveState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt  = state;
    ctrl = '0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          nxt = S_DECIDE;
        end
      end
      S_DECIDE: begin
        if (specBad) begin
          ctrl.setSpec = 1'b1;
          nxt = S_FINISH;
        end else begin
          ctrl.setStatus = 1'b1;
          if (overlapBad || dstZero) nxt = S_FINISH;
          else if (copyZero)         nxt = S_PAD;
          else                       nxt = S_READ;
        end
      end
      S_READ: begin
        ctrl.useSrc = 1'b1;
        if (memAck) begin
          ctrl.latchData = 1'b1;
          nxt = S_WRITE;
        end
      end
      S_WRITE: begin
        if (memAck) begin
          ctrl.stepCopy = 1'b1;
          if (!copyLast)    nxt = S_READ;
          else if (dstLast) nxt = S_FINISH;
          else              nxt = S_PAD;
        end
      end
      S_PAD: begin
        ctrl.usePad = 1'b1;
        if (memAck) begin
          ctrl.stepPad = 1'b1;
          if (dstLast) nxt = S_FINISH;
        end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign memReq = (state == S_READ) || (state == S_WRITE) || (state == S_PAD);
  assign memWe  = (state == S_WRITE) || (state == S_PAD);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FINISH);

endmodule

// File: rtl/pad_move_engine.sv
module pad_move_engine
  import lme_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int REGN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [REGN_W-1:0] dstRegNum,
  input  logic [REGN_W-1:0] srcRegNum,
  input  logic [WORD_W-1:0] dstAddrIn,
  input  logic [WORD_W-1:0] dstLenIn,
  input  logic [WORD_W-1:0] srcAddrIn,
  input  logic [WORD_W-1:0] srcLenIn,
  output logic              busy,
  output logic              done,
  output logic              specErr,
  output logic [1:0]        status,
  output logic [WORD_W-1:0] dstAddrOut,
  output logic [WORD_W-1:0] dstLenOut,
  output logic [WORD_W-1:0] srcAddrOut,
  output logic [WORD_W-1:0] srcLenOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  dpCtrl_t ctrl;
  logic specBad, overlapBad, dstZero, dstLast, copyZero, copyLast;

  lme_control ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck),
    .specBad(specBad), .overlapBad(overlapBad), .dstZero(dstZero),
    .dstLast(dstLast), .copyZero(copyZero), .copyLast(copyLast),
    .ctrl(ctrl), .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );

  lme_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGN_W(REGN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .dstRegNum(dstRegNum), .srcRegNum(srcRegNum),
    .dstAddrIn(dstAddrIn), .dstLenIn(dstLenIn),
    .srcAddrIn(srcAddrIn), .srcLenIn(srcLenIn), .memRdata(memRdata),
    .specBad(specBad), .overlapBad(overlapBad), .dstZero(dstZero),
    .dstLast(dstLast), .copyZero(copyZero), .copyLast(copyLast),
    .memAddr(memAddr), .memWdata(memWdata), .specErr(specErr),
    .status(status), .dstAddrOut(dstAddrOut), .dstLenOut(dstLenOut),
    .srcAddrOut(srcAddrOut), .srcLenOut(srcLenOut)
  );

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R1
  spec_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    specErr |-> !memReq);

  // R5
  overlap_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd3) |-> !memReq);

  // R7
  len_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !specErr && status != 2'd3) |-> (dstLenOut == '0));

endmodule

// File: tb/pad_move_engine_tb_top.sv
module pad_move_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AMASK = 'hFFFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  dstRegNum = '0, srcRegNum = '0;
  logic [31:0] dstAddrIn = '0, dstLenIn = '0, srcAddrIn = '0, srcLenIn = '0;
  logic        busy, done, specErr, memReq, memWe;
  logic [1:0]  status;
  logic [31:0] dstAddrOut, dstLenOut, srcAddrOut, srcLenOut;
  logic [23:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        memAck = 1'b0;

  int compared = 0, mismatched = 0, cycleCnt = 0, ackCnt = 0;
  logic [7:0] memArr [int];
  logic       expWe[$];
  int         expAddr[$];
  logic [7:0] expData[$];
  logic       qWe;
  int         qAddr;
  logic [7:0] qData;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_move_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dstRegNum(dstRegNum), .srcRegNum(srcRegNum),
    .dstAddrIn(dstAddrIn), .dstLenIn(dstLenIn), .srcAddrIn(srcAddrIn), .srcLenIn(srcLenIn),
    .busy(busy), .done(done), .specErr(specErr), .status(status),
    .dstAddrOut(dstAddrOut), .dstLenOut(dstLenOut), .srcAddrOut(srcAddrOut), .srcLenOut(srcLenOut),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [7:0] seedByte(int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] rdMem(int a);
    if (memArr.exists(a)) return memArr[a];
    return seedByte(a);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder and per-clock bus comparison
  always @(negedge clk) begin
    cycleCnt++;
    memAck = 1'b0;
    if (rstN) begin
      chk(busy || !memReq, "R10", "request while idle", longint'(memReq), 0);
      if (memReq) begin
        ackCnt++;
        if (ackCnt % 3 != 0) begin
          memAck   = 1'b1;
          memRdata = rdMem({8'h0, memAddr});
          if (expWe.size() == 0) begin
            chk(0, "R1/R5/R9", "unexpected transfer at", longint'(memAddr), 0);
          end else begin
            qWe   = expWe.pop_front();
            qAddr = expAddr.pop_front();
            qData = expData.pop_front();
            chk(memWe == qWe && {8'h0, memAddr} == qAddr && (!qWe || memWdata == qData),
                "R3/R4/R6", "transfer {we,addr,data}",
                longint'({memWe, memAddr, memWdata}), longint'({qWe, qAddr[23:0], qData}));
          end
          if (memWe) memArr[{8'h0, memAddr}] = memWdata;
        end
      end
    end
    if (cycleCnt > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycleCnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic runMove(string tag, logic [3:0] dR, logic [3:0] sR,
                         logic [31:0] dA, logic [31:0] dL, logic [31:0] sA, logic [31:0] sW);
    int da, dl, sa, sl, cn, off, n, s, t;
    int eDa, eDl, eSa, eSl, eSt;
    bit spec, ovl, quick;
    logic [7:0] pad, v;
    logic [7:0] sh [int];
    da = int'(dA[23:0]); dl = int'(dL[23:0]);
    sa = int'(sA[23:0]); sl = int'(sW[23:0]);
    pad  = sW[31:24];
    spec = dR[0] | sR[0];
    cn   = (dl < sl) ? dl : sl;
    off  = (da - sa) & AMASK;
    ovl  = !spec && off != 0 && off < cn;
    quick = spec || ovl || dl == 0;
    if (spec)          eSt = 0;
    else if (ovl)      eSt = 3;
    else if (dl == sl) eSt = 0;
    else if (dl < sl)  eSt = 1;
    else               eSt = 2;
    if (spec || ovl) begin
      eDa = da; eDl = dl; eSa = sa; eSl = sl;
    end else begin
      for (int i = 0; i < cn; i++) begin
        s = (sa + i) & AMASK;
        t = (da + i) & AMASK;
        v = sh.exists(s) ? sh[s] : rdMem(s);
        expWe.push_back(1'b0); expAddr.push_back(s); expData.push_back(8'h0);
        expWe.push_back(1'b1); expAddr.push_back(t); expData.push_back(v);
        sh[t] = v;
      end
      for (int i = cn; i < dl; i++) begin
        expWe.push_back(1'b1); expAddr.push_back((da + i) & AMASK); expData.push_back(pad);
      end
      eDa = (da + dl) & AMASK; eDl = 0; eSa = (sa + cn) & AMASK; eSl = sl - cn;
    end
    @(negedge clk);
    dstRegNum = dR; srcRegNum = sR;
    dstAddrIn = dA; dstLenIn = dL; srcAddrIn = sA; srcLenIn = sW;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R9", {tag, " done seen"}, longint'(done), 1);
    if (quick) chk(n == 1, "R9", {tag, " cycles to done"}, n + 1, 2);
    chk(specErr == spec, "R1", {tag, " specErr"}, longint'(specErr), longint'(spec));
    chk(int'(status) == eSt, "R5/R8", {tag, " status"}, longint'(status), eSt);
    chk(dstAddrOut == eDa, "R7/R6", {tag, " dst addr"}, longint'(dstAddrOut), eDa);
    chk(dstLenOut == eDl, "R7", {tag, " dst len"}, longint'(dstLenOut), eDl);
    chk(srcAddrOut == eSa, "R7/R6", {tag, " src addr"}, longint'(srcAddrOut), eSa);
    chk(srcLenOut == eSl, "R7", {tag, " src len"}, longint'(srcLenOut), eSl);
    chk(expWe.size() == 0, "R3/R4", {tag, " transfers left"}, expWe.size(), 0);
    expWe.delete(); expAddr.delete(); expData.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReq, "R10", "reset idle {busy,done,req}",
        longint'({busy, done, memReq}), 0);
    chk(dstLenOut == 0 && status == 0, "R7", "reset results", longint'(dstLenOut), 0);
    rstN = 1'b1;
    // R8 equal lengths; R2 garbage in ignored upper bytes
    runMove("R2 equal", 4'd2, 4'd4, 32'hAB000100, 32'h77000005, 32'hCD000400, {8'h5A, 24'd5});
    // R4 destination longer, pad tail
    runMove("R4 pad", 4'd6, 4'd8, 32'h00000500, 32'd8, 32'h00000600, {8'hEE, 24'd3});
    // R3 destination shorter, source tail not read
    runMove("R3 short", 4'd0, 4'd2, 32'h00000700, 32'd3, 32'h00000800, {8'h11, 24'd7});
    // R9 zero destination length
    runMove("R9 zero", 4'd2, 4'd4, 32'h00000900, 32'd0, 32'h00000A00, {8'h22, 24'd4});
    // R1 odd destination register, then odd source register
    runMove("R1 odd dst", 4'd3, 4'd4, 32'hFF000B00, 32'd4, 32'h00000C00, {8'h33, 24'd4});
    runMove("R1 odd src", 4'd2, 4'd5, 32'h00000B00, 32'd4, 32'h00000C00, {8'h33, 24'd4});
    // R5 destructive overlap refused
    runMove("R5 overlap", 4'd2, 4'd4, 32'h00001102, 32'd6, 32'h00001100, {8'h44, 24'd6});
    // R5 destination below source proceeds
    runMove("R5 below", 4'd2, 4'd4, 32'h00001200, 32'd6, 32'h00001202, {8'h44, 24'd6});
    // R5 offset equal to copy count proceeds
    runMove("R5 edge", 4'd2, 4'd4, 32'h00001306, 32'd6, 32'h00001300, {8'h44, 24'd6});
    // R5 identical addresses proceed
    runMove("R5 same", 4'd2, 4'd4, 32'h00001400, 32'd3, 32'h00001400, {8'h44, 24'd3});
    // R6 source wraps
    runMove("R6 src wrap", 4'd2, 4'd4, 32'h00000100, 32'd6, 32'h00FFFFFE, {8'h66, 24'd4});
    // R6 destination wraps during pad
    runMove("R6 dst wrap", 4'd2, 4'd4, 32'h00FFFFFD, 32'd6, 32'h00000200, {8'h77, 24'd2});
    // R4 empty source, all pad
    runMove("R4 all pad", 4'd2, 4'd4, 32'h00002000, 32'd4, 32'h00003000, {8'h99, 24'd0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule